// File: doc/BRIEF.md
# Bad Line Detector and Bus Request

This block decides, line by line, whether the video fetch unit must take the memory bus away from the processor to read character pointers. A line that needs this is a "bad line". The block gets the current raster line number, the cycle index within that line, and the write strobe and data of the vertical control register. From the register data it keeps the 3-bit vertical scroll value and the display-enable bit.

A bad line needs three things. The line must lie in the fetch window, lines 0x30 to 0xf7. The low three bits of the line number must equal the scroll value. An enable latch must be set. That latch can only change on the first window line. When the block finds a bad line, it raises its own bus request. It merges this request with the sprite unit's request into one active-high bus-available output. When that output is low, the processor is stalled.

A register write in the middle of a line can start a bad line at once. Software uses this to create or move bad lines on the fly.

Top module: `fetch_stall_ctrl`

## Requirements
- R1: After reset the bad-line flag is 0, the own bus request is released and the enable latch is clear, so no bad line can occur until the latch is set.
- R2: A bad line is recognised only on lines 0x30 through 0xf7 inclusive. With scroll 3 and the latch set, exactly 25 lines of a frame (0x33, 0x3b, ... 0xf3) are bad.
- R3: A bad line needs the line number's bits 2..0 to equal the stored scroll value, which is bits 2..0 of the last control-register write.
- R4: In cycle 20 of line 0x30 the enable latch is loaded from bit 4 of the control register (the value written in that cycle if a write coincides). With bit 4 clear at that point, no line of the frame is bad.
- R5: In cycle 20 of every line the condition is evaluated. The flag and the own request take effect one clock later, so busAvail is 0 from the sample after cycle 20 when the line is bad.
- R6: A control-register write in a cycle below 11 updates only the stored scroll and enable bits. The bad-line flag and the request keep their values in the following clock.
- R7: A write with bit 4 set, on line 0x30, in cycle 11 or later, forces the enable latch to 1 at once.
- R8: A write in cycle 11 or later re-evaluates the condition with the new value. If the line is now bad and the cycle is below 53, the request asserts on the next clock. In cycle 53 or later only the flag changes.
- R9: The own request is released in cycle 63 (in cycle 0 when a line has 63 cycles or fewer). busAvail returns to 1 one clock later unless the sprite request is active.
- R10: busAvail is the inverse of the OR of the own request and the sprite request input. The sprite input acts combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot-cycle clock, one edge per line cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| lineNum | input | 9 | Current raster line |
| lineCycle | input | 7 | Cycle index inside the line |
| ctlWrEn | input | 1 | Write strobe of the vertical control register |
| ctlWrData | input | 8 | Write data: bits 2..0 scroll, bit 4 display enable |
| spriteBusReq | input | 1 | Bus request from the sprite unit |
| badLine | output | 1 | Current line is a bad line |
| busAvail | output | 1 | 1 = bus free for the processor, 0 = stalled |

## Verification
The hardest case to reach is a mid-line write that changes the outcome after cycle 20 has already decided the line. This happens when display enable is forced on late in line 0x30, when scroll is moved onto the current line before and after cycle 53, or when a write comes early in a line while a stale flag is still high. The bench plays whole frames of line and cycle counts, three frames in a row. Each frame has a different schedule of register writes that lands in exactly those cycles. A reference model built from the requirements checks the flag and bus output on every cycle.

// File: rtl/fetch_stall_pkg.sv
package fetch_stall_pkg;
  typedef struct packed {
    logic evalStb;     // cycle-20 evaluation point
    logic onFirstLine; // current line is the first window line
    logic inWindow;    // current line inside fetch window
    logic lateWrite;   // write in a cycle that re-evaluates
    logic reqAllowed;  // a fresh bad line may raise the request now
    logic releaseStb;  // drop own request
  } ctlStrobes_t;
endpackage

// File: rtl/fetch_stall_ctl.sv
module fetch_stall_ctl
  import fetch_stall_pkg::*;
#(
  parameter int LINE_W = 9,
  parameter int CYC_W = 7,
  parameter int FIRST_LINE = 'h30,
  parameter int LAST_LINE = 'h f7,
  parameter int EVAL_CYCLE = 20,
  parameter int WRITE_EVAL_MIN = 11,
  parameter int REQ_LIMIT = 53,
  parameter int RELEASE_CYCLE = 63
) (
  input  logic [LINE_W-1:0] lineNum,
  input  logic [CYC_W-1:0]  lineCycle,
  input  logic              ctlWrEn,
  output ctlStrobes_t       strobes
);
  localparam logic [LINE_W-1:0] FirstL = LINE_W'(FIRST_LINE);
  localparam logic [LINE_W-1:0] LastL  = LINE_W'(LAST_LINE);
  localparam logic [CYC_W-1:0]  EvalC  = CYC_W'(EVAL_CYCLE);
  localparam logic [CYC_W-1:0]  WrMinC = CYC_W'(WRITE_EVAL_MIN);
  localparam logic [CYC_W-1:0]  LimC   = CYC_W'(REQ_LIMIT);
  localparam logic [CYC_W-1:0]  RelC   = CYC_W'(RELEASE_CYCLE);

  logic isEval;
  logic isLate;

  always_comb begin
    isEval = (lineCycle == EvalC);
    isLate = ctlWrEn && (lineCycle >= WrMinC);
    strobes.evalStb     = isEval;
    strobes.onFirstLine = (lineNum == FirstL);
    strobes.inWindow    = (lineNum >= FirstL) && (lineNum <= LastL);
    strobes.lateWrite   = isLate;
    strobes.reqAllowed  = isEval || (isLate && (lineCycle < LimC));
    strobes.releaseStb  = (lineCycle == RelC);
  end
endmodule

// File: rtl/fetch_stall_dp.sv
module fetch_stall_dp
  import fetch_stall_pkg::*;
#(
  parameter int LINE_W = 9,
  parameter int SCROLL_W = 3,
  parameter int DATA_W = 8,
  parameter int DEN_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              ctlWrEn,
  input  logic [DATA_W-1:0] ctlWrData,
  input  ctlStrobes_t       strobes,
  output logic              badLine,
  output logic              dmaReq
);
  logic [SCROLL_W-1:0] scrollQ, scrollEff;
  logic denQ, denEff;
  logic enLatchQ, enLatchNext;
  logic condNext;

  always_comb begin
    scrollEff = ctlWrEn ? ctlWrData[SCROLL_W-1:0] : scrollQ;
    denEff    = ctlWrEn ? ctlWrData[DEN_BIT] : denQ;
    enLatchNext = enLatchQ;
    if (strobes.evalStb && strobes.onFirstLine)
      enLatchNext = denEff;
    else if (strobes.lateWrite && strobes.onFirstLine && ctlWrData[DEN_BIT])
      enLatchNext = 1'b1;
    condNext = strobes.inWindow && enLatchNext &&
               (lineNum[SCROLL_W-1:0] == scrollEff);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scrollQ  <= '0;
      denQ     <= 1'b0;
      enLatchQ <= 1'b0;
      badLine  <= 1'b0;
      dmaReq   <= 1'b0;
    end else begin
      if (ctlWrEn) begin
        scrollQ <= ctlWrData[SCROLL_W-1:0];
        denQ    <= ctlWrData[DEN_BIT];
      end
      enLatchQ <= enLatchNext;
      if (strobes.evalStb || strobes.lateWrite)
        badLine <= condNext;
      if (strobes.releaseStb)
        dmaReq <= 1'b0;
      else if (condNext && strobes.reqAllowed)
        dmaReq <= 1'b1;
    end
  end

  AST_REQ_NEEDS_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dmaReq) |-> badLine); // R8
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.releaseStb |=> !dmaReq); // R9
  AST_EARLY_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlWrEn && !strobes.lateWrite && !strobes.evalStb) |=> $stable(badLine)); // R6
  AST_LATCH_FIRST_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enLatchQ) |-> $past(strobes.onFirstLine)); // R4
  AST_BAD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(badLine) |-> $past(strobes.inWindow)); // R2
  AST_SCROLL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(badLine) |-> ($past(lineNum[SCROLL_W-1:0]) == scrollQ)); // R3
endmodule

// File: rtl/fetch_stall_ctrl.sv
module fetch_stall_ctrl
  import fetch_stall_pkg::*;
#(
  parameter int LINE_W = 9,
  parameter int CYC_W = 7,
  parameter int DATA_W = 8,
  parameter int SCROLL_W = 3,
  parameter int DEN_BIT = 4,
  parameter int FIRST_LINE = 'h30,
  parameter int LAST_LINE = 'hf7,
  parameter int LINE_CYCLES = 65,
  parameter int EVAL_CYCLE = 20,
  parameter int WRITE_EVAL_MIN = 11,
  parameter int REQ_LIMIT = 53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] lineNum,
  input  logic [CYC_W-1:0]  lineCycle,
  input  logic              ctlWrEn,
  input  logic [DATA_W-1:0] ctlWrData,
  input  logic              spriteBusReq,
  output logic              badLine,
  output logic              busAvail
);
  localparam int ReleaseCycle = (LINE_CYCLES > 63) ? 63 : 0;

  ctlStrobes_t strobes;
  logic dmaReq;

  fetch_stall_ctl #(
    .LINE_W(LINE_W), .CYC_W(CYC_W), .FIRST_LINE(FIRST_LINE),
    .LAST_LINE(LAST_LINE), .EVAL_CYCLE(EVAL_CYCLE),
    .WRITE_EVAL_MIN(WRITE_EVAL_MIN), .REQ_LIMIT(REQ_LIMIT),
    .RELEASE_CYCLE(ReleaseCycle)
  ) i_ctl (
    .lineNum(lineNum), .lineCycle(lineCycle), .ctlWrEn(ctlWrEn),
    .strobes(strobes)
  );

  fetch_stall_dp #(
    .LINE_W(LINE_W), .SCROLL_W(SCROLL_W), .DATA_W(DATA_W), .DEN_BIT(DEN_BIT)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .lineNum(lineNum), .ctlWrEn(ctlWrEn),
    .ctlWrData(ctlWrData), .strobes(strobes), .badLine(badLine),
    .dmaReq(dmaReq)
  );

  assign busAvail = !(dmaReq || spriteBusReq);

  AST_SPRITE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    spriteBusReq |-> !busAvail); // R10
  AST_OWN_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (dmaReq && !$past(strobes.releaseStb)) |-> !busAvail); // R5
endmodule

// File: tb/test_fetch_stall_ctrl.sv
module test_fetch_stall_ctrl;
  localparam int ClkPeriod = 10;
  localparam int NumLines = 263;
  localparam int NumCycles = 65;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] lineNum = '0;
  logic [6:0] lineCycle = '0;
  logic ctlWrEn = 1'b0;
  logic [7:0] ctlWrData = '0;
  logic spriteBusReq = 1'b0;
  logic badLine, busAvail;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  logic [2:0] mScroll = '0;
  logic mDen = 0, mEn = 0, mBad = 0, mReq = 0;

  fetch_stall_ctrl i_fetch_stall_ctrl (
    .clk(clk), .rst_n(rst_n), .lineNum(lineNum), .lineCycle(lineCycle),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .spriteBusReq(spriteBusReq),
    .badLine(badLine), .busAvail(busAvail)
  );

  always #(ClkPeriod/2) clk = ~clk;

  initial begin
    #(ClkPeriod * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s line=%0h cyc=%0d actual=%0b expected=%0b",
               tag, lineNum, lineCycle, act, exp);
    end
  endtask

  // one clock: inputs already driven; update model, advance edge, compare
  task automatic tick(input string tag);
    logic [2:0] sEff; logic dEff, en, c;
    int cyc;
    cyc = int'(lineCycle);
    sEff = ctlWrEn ? ctlWrData[2:0] : mScroll;
    dEff = ctlWrEn ? ctlWrData[4] : mDen;
    en = mEn;
    if (cyc == 20 && lineNum == 9'h30) en = dEff;
    else if (ctlWrEn && cyc >= 11 && lineNum == 9'h30 && ctlWrData[4]) en = 1;
    c = (lineNum >= 9'h30) && (lineNum <= 9'hf7) && (lineNum[2:0] == sEff) && en;
    if (cyc == 20 || (ctlWrEn && cyc >= 11)) mBad = c;
    if (cyc == 63) mReq = 0;
    else if (c && (cyc == 20 || (ctlWrEn && cyc >= 11 && cyc < 53))) mReq = 1;
    mEn = en; mScroll = sEff; mDen = dEff;
    @(posedge clk); #1;
    check({tag, " badLine"}, badLine, mBad);
    check({tag, " busAvail"}, busAvail, !(mReq || spriteBusReq));
    @(negedge clk);
  endtask

  // frame with a write schedule chosen per frame index
  task automatic run_frame(input int fr, output int badCount);
    badCount = 0;
    for (int ln = 0; ln < NumLines; ln++) begin
      for (int cy = 0; cy < NumCycles; cy++) begin
        string tag;
        lineNum = 9'(ln); lineCycle = 7'(cy);
        ctlWrEn = 0; ctlWrData = '0;
        spriteBusReq = (ln == 'h40 || ln == 'h90) && cy < 10;
        if (ln == 0 && cy == 5) begin
          ctlWrEn = 1;
          ctlWrData = (fr == 0) ? 8'h13 : (fr == 1) ? 8'h03 : 8'h00;
        end
        if (fr == 2) begin
          if (ln == 'h30 && cy == 30) begin ctlWrEn = 1; ctlWrData = 8'h10; end
          if (ln == 'h51 && cy == 55) begin ctlWrEn = 1; ctlWrData = 8'h11; end
          if (ln == 'h52 && cy == 8)  begin ctlWrEn = 1; ctlWrData = 8'h12; end
          if (ln == 'h60 && cy == 40) begin ctlWrEn = 1; ctlWrData = 8'h10; end
        end
        if (ctlWrEn && cy < 11) tag = "R6";
        else if (ctlWrEn) tag = (ln == 'h30) ? "R7" : "R8";
        else if (cy == 20) tag = "R5";
        else if (cy == 63) tag = "R9";
        else if (spriteBusReq) tag = "R10";
        else tag = "R3";
        tick(tag);
        if (cy == 20 && badLine) badCount++;
        if (fr == 2 && ln == 'h30 && cy == 30) begin
          check("R7 forced bad", badLine, 1'b1);
          check("R7 request", busAvail, 1'b0);
        end
        if (fr == 2 && ln == 'h51 && cy == 55) begin
          check("R8 late flag", badLine, 1'b1);
          check("R8 no late request", busAvail, 1'b1);
        end
        if (fr == 2 && ln == 'h52 && cy == 8)
          check("R6 flag held", badLine, 1'b1);
        if (fr == 0 && ln == 'h33 && cy == 63)
          check("R9 released", busAvail, 1'b1);
      end
    end
  endtask

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    check("R1 reset badLine", badLine, 1'b0);
    check("R1 reset busAvail", busAvail, 1'b1);
    @(negedge clk);
    rst_n = 1;
    // R1: latch clear, scroll 0 -> line 0x38 cycle 20 must not be bad
    lineNum = 9'h38; lineCycle = 7'd20;
    tick("R1");
    check("R1 latch clear", badLine, 1'b0);
    run_frame(0, cnt);
    total++;
    if (cnt != 25) begin bad++; $display("FAIL R2 bad lines actual=%0d expected=25", cnt); end
    run_frame(1, cnt);
    total++;
    if (cnt != 0) begin bad++; $display("FAIL R4 bad lines actual=%0d expected=0", cnt); end
    run_frame(2, cnt);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule